// File: doc/BRIEF.md
# LDPC Variable-Node Unit with Outer-Code Clamping

This unit performs the bit-side update of a sum-product LDPC decoder for one code bit. It forms a channel log-likelihood value from the received sample and a programmable scale factor that stands for 2/σ². It keeps a local copy of the check-to-bit messages on each of the node's edges. From the channel value and those messages it produces one extrinsic bit-to-check message per edge, the a-posteriori value and a hard decision.

When an outer hard-decision decoder has already validated the bit, the bit is marked reliable. The unit then ignores every check message. Its channel value, every outgoing message and its posterior are all forced to the scale value, with the sign chosen by the outer decision bit.

All arithmetic is signed fixed point, and every result saturates to the message width. Results are registered one cycle after the request strobe.

Top module: `ldpc_bitnode`

## Requirements
- R1: For a bit not marked reliable, the channel value is floor(sample × scale / 2^FRAC_Y), saturated to MSG_W bits. The sample is signed and carries FRAC_Y fraction bits; the scale is unsigned. The outer decision bit has no effect on this value.
- R2: For a reliable bit, the channel value is +scale when the outer decision bit is 0 and −scale when it is 1, saturated to MSG_W bits.
- R3: A pulse on `run_start` clears every stored check message to zero. If `cmsg_we` is high in the same cycle, `run_start` takes priority.
- R4: For a bit not marked reliable, the message on edge k equals the channel value plus the sum of the stored check messages on all edges except k, saturated. Edge k occupies bits [k·MSG_W +: MSG_W] of both message buses.
- R5: For a reliable bit, the message on every edge equals the channel value, whatever the stored check messages are.
- R6: The posterior is the channel value plus the sum of all stored check messages, saturated, for a bit not marked reliable. For a reliable bit it is the channel value alone.
- R7: The hard decision is 1 when the posterior is ≤ 0, including exactly zero, and 0 when it is positive.
- R8: Every saturated result is clamped to the range [−2^(MSG_W−1), 2^(MSG_W−1)−1] and never wraps.
- R9: `vld_out` is high exactly one cycle after `vld_in`. Outputs change only on a cycle that follows `vld_in`, and hold their values otherwise.
- R10: During reset and after it, until the first request, `vld_out`, every message, the posterior and the hard decision are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run_start | input | 1 | Clears the stored check messages at the start of a decoding run |
| cmsg_we | input | 1 | Writes `cmsg_in` into the message store |
| cmsg_in | input | DEG×MSG_W | Incoming check-to-bit messages, edge k at [k·MSG_W +: MSG_W] |
| vld_in | input | 1 | Requests an update from the current inputs and the stored messages |
| samp_in | input | SAMP_W | Signed received sample with FRAC_Y fraction bits |
| scale_in | input | SCALE_W | Unsigned scale standing for 2/σ² |
| reliable_in | input | 1 | Bit already validated by the outer code |
| outer_bit_in | input | 1 | Outer-code decision for this bit |
| vld_out | output | 1 | Results valid |
| vmsg_out | output | DEG×MSG_W | Outgoing bit-to-check messages, edge k at [k·MSG_W +: MSG_W] |
| post_out | output | MSG_W | Saturated a-posteriori value |
| hard_out | output | 1 | Hard decision |

## Verification
The hardest case to reach from the ports is a posterior of exactly zero on a non-reliable bit whose stored messages are non-zero. It also matters that messages which are not themselves extreme still drive the total past both clamp limits. The bench loads chosen message sets through the write port and sweeps every sample value against several scales. It also places directed sets whose sum cancels the channel value exactly. Clearing is checked by loading large messages and then pulsing `run_start` together with a write, before the next request.

// File: rtl/vn_pkg.sv
package vn_pkg;
  // Source of the channel value
  typedef enum logic {
    SRC_SAMPLE = 1'b0,
    SRC_OUTER  = 1'b1
  } chan_src_e;
endpackage

// File: rtl/vn_sat.sv
module vn_sat #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 8
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam logic signed [IN_W-1:0] HI = IN_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [IN_W-1:0] LO = IN_W'(-(2 ** (OUT_W - 1)));

  always_comb begin
    if (din > HI) begin
      dout = {1'b0, {(OUT_W-1){1'b1}}};
    end else if (din < LO) begin
      dout = {1'b1, {(OUT_W-1){1'b0}}};
    end else begin
      dout = din[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/vn_chan.sv
module vn_chan
  import vn_pkg::*;
#(
  parameter int SAMP_W  = 6,
  parameter int SCALE_W = 5,
  parameter int FRAC_Y  = 2,
  parameter int MSG_W   = 8
) (
  input  logic signed [SAMP_W-1:0] sample,
  input  logic [SCALE_W-1:0]       scale,
  input  logic                     reliable,
  input  logic                     outer_bit,
  output logic signed [MSG_W-1:0]  chan
);
  localparam int PW = SAMP_W + SCALE_W + 1;

  chan_src_e             src;
  logic signed [PW-1:0]  prod;
  logic signed [PW-1:0]  scaled;
  logic signed [PW-1:0]  pos_unit;
  logic signed [PW-1:0]  outer_val;
  logic signed [PW-1:0]  raw;

  always_comb begin
    src       = reliable ? SRC_OUTER : SRC_SAMPLE;
    pos_unit  = PW'($signed({1'b0, scale}));
    prod      = PW'(sample) * pos_unit;
    scaled    = prod >>> FRAC_Y;
    outer_val = outer_bit ? -pos_unit : pos_unit;
    case (src)
      SRC_OUTER: raw = outer_val;
      default:   raw = scaled;
    endcase
  end

  vn_sat #(.IN_W(PW), .OUT_W(MSG_W)) u_sat (
    .din  (raw),
    .dout (chan)
  );
endmodule

// File: rtl/vn_store.sv
module vn_store #(
  parameter int DEG   = 3,
  parameter int MSG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   we,
  input  logic [DEG*MSG_W-1:0]   din,
  output logic [DEG*MSG_W-1:0]   q
);
  logic [DEG*MSG_W-1:0] q_nxt;
  logic                 q_en;

  always_comb begin
    q_en  = clr | we;
    q_nxt = clr ? '0 : din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end

  // R3: a clear leaves every stored message at zero, even under a write
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
  // R3: without clear or write the store holds
  a_r3_store_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !we) |=> $stable(q));
endmodule

// File: rtl/vn_sum.sv
module vn_sum #(
  parameter int DEG   = 3,
  parameter int MSG_W = 8
) (
  input  logic signed [MSG_W-1:0] chan,
  input  logic [DEG*MSG_W-1:0]    cmsg,
  input  logic                    reliable,
  output logic [DEG*MSG_W-1:0]    vmsg,
  output logic signed [MSG_W-1:0] post
);
  localparam int TW = MSG_W + $clog2(DEG + 1) + 1;

  logic signed [TW-1:0]    total;
  logic signed [MSG_W-1:0] post_sat;
  logic [DEG*MSG_W-1:0]    ext_sat;

  always_comb begin
    total = TW'(chan);
    for (int k = 0; k < DEG; k++) begin
      total = total + TW'($signed(cmsg[k*MSG_W +: MSG_W]));
    end
  end

  vn_sat #(.IN_W(TW), .OUT_W(MSG_W)) u_sat_post (
    .din  (total),
    .dout (post_sat)
  );

  for (genvar g = 0; g < DEG; g++) begin : g_edge
    logic signed [TW-1:0]    ext_w;
    logic signed [MSG_W-1:0] ext_s;
    assign ext_w = total - TW'($signed(cmsg[g*MSG_W +: MSG_W]));
    vn_sat #(.IN_W(TW), .OUT_W(MSG_W)) u_sat_ext (
      .din  (ext_w),
      .dout (ext_s)
    );
    assign ext_sat[g*MSG_W +: MSG_W] = ext_s;
    assign vmsg[g*MSG_W +: MSG_W]    = reliable ? chan : ext_s;
  end

  assign post = reliable ? chan : post_sat;

  always_comb begin
    // R5: a reliable bit sends its channel value on every edge
    if (reliable) begin
      a_r5_flat_edges: assert (vmsg == {DEG{chan}});
    end
  end
endmodule

// File: rtl/ldpc_bitnode.sv
module ldpc_bitnode #(
  parameter int DEG     = 3,
  parameter int SAMP_W  = 6,
  parameter int SCALE_W = 5,
  parameter int FRAC_Y  = 2,
  parameter int MSG_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_start,
  input  logic                     cmsg_we,
  input  logic [DEG*MSG_W-1:0]     cmsg_in,
  input  logic                     vld_in,
  input  logic signed [SAMP_W-1:0] samp_in,
  input  logic [SCALE_W-1:0]       scale_in,
  input  logic                     reliable_in,
  input  logic                     outer_bit_in,
  output logic                     vld_out,
  output logic [DEG*MSG_W-1:0]     vmsg_out,
  output logic signed [MSG_W-1:0]  post_out,
  output logic                     hard_out
);
  logic signed [MSG_W-1:0] chan;
  logic [DEG*MSG_W-1:0]    cmsg_q;
  logic [DEG*MSG_W-1:0]    vmsg_nxt;
  logic signed [MSG_W-1:0] post_nxt;
  logic                    hard_nxt;
  logic                    rel_q;
  logic                    res_en;

  vn_chan #(
    .SAMP_W(SAMP_W), .SCALE_W(SCALE_W), .FRAC_Y(FRAC_Y), .MSG_W(MSG_W)
  ) u_chan (
    .sample    (samp_in),
    .scale     (scale_in),
    .reliable  (reliable_in),
    .outer_bit (outer_bit_in),
    .chan      (chan)
  );

  vn_store #(.DEG(DEG), .MSG_W(MSG_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (run_start),
    .we    (cmsg_we),
    .din   (cmsg_in),
    .q     (cmsg_q)
  );

  vn_sum #(.DEG(DEG), .MSG_W(MSG_W)) u_sum (
    .chan     (chan),
    .cmsg     (cmsg_q),
    .reliable (reliable_in),
    .vmsg     (vmsg_nxt),
    .post     (post_nxt)
  );

  always_comb begin
    res_en   = vld_in;
    hard_nxt = (post_nxt <= 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_out <= 1'b0;
    end else begin
      vld_out <= vld_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmsg_out <= '0;
      post_out <= '0;
      hard_out <= 1'b0;
      rel_q    <= 1'b0;
    end else if (res_en) begin
      vmsg_out <= vmsg_nxt;
      post_out <= post_nxt;
      hard_out <= hard_nxt;
      rel_q    <= reliable_in;
    end
  end

  // R9: one-cycle latency, no spurious valid
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in |=> vld_out);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_in |=> !vld_out);
  // R9: results hold between requests
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_in |=> ($stable(post_out) && $stable(vmsg_out) && $stable(hard_out)));
  // R7: registered decision agrees with registered posterior sign
  a_r7_hard_sign: assert property (@(posedge clk) disable iff (!rst_n)
    vld_out |-> (hard_out == (post_out <= 0)));
  // R5 / R6: a reliable result has every edge equal to the posterior
  a_r6_reliable_post: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_out && rel_q) |-> (vmsg_out == {DEG{post_out}}));
endmodule

// File: tb/ldpc_bitnode_bench.sv
module ldpc_bitnode_bench;
  localparam int DEG = 3, SAMP_W = 6, SCALE_W = 5, FRAC_Y = 2, MSG_W = 8;
  localparam int HI = 127, LO = -128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_start = 1'b0, cmsg_we = 1'b0, vld_in = 1'b0;
  logic [DEG*MSG_W-1:0] cmsg_in = '0;
  logic signed [SAMP_W-1:0] samp_in = '0;
  logic [SCALE_W-1:0] scale_in = '0;
  logic reliable_in = 1'b0, outer_bit_in = 1'b0;
  logic vld_out;
  logic [DEG*MSG_W-1:0] vmsg_out;
  logic signed [MSG_W-1:0] post_out;
  logic hard_out;

  int n_run = 0, n_fail = 0;
  int cur [DEG];
  bit done = 0;

  always #2.5 clk = ~clk;

  ldpc_bitnode u_ldpc_bitnode (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .cmsg_we(cmsg_we),
    .cmsg_in(cmsg_in), .vld_in(vld_in), .samp_in(samp_in), .scale_in(scale_in),
    .reliable_in(reliable_in), .outer_bit_in(outer_bit_in), .vld_out(vld_out),
    .vmsg_out(vmsg_out), .post_out(post_out), .hard_out(hard_out)
  );

  function automatic int sat(input int v);
    return (v > HI) ? HI : (v < LO) ? LO : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int m0, input int m1, input int m2);
    @(negedge clk);
    cmsg_we = 1'b1;
    cmsg_in = {MSG_W'(m2), MSG_W'(m1), MSG_W'(m0)};
    cur[0] = m0; cur[1] = m1; cur[2] = m2;
    @(negedge clk);
    cmsg_we = 1'b0;
  endtask

  // R1 R2 R4 R5 R6 R7 R8 R9: one request and its full check
  task automatic fire(input int y, input int s, input bit rel, input bit d);
    int r, tot, pe;
    @(negedge clk);
    vld_in = 1'b1; samp_in = SAMP_W'(y); scale_in = SCALE_W'(s);
    reliable_in = rel; outer_bit_in = d;
    if (rel) r = sat(d ? -s : s);
    else     r = sat((y * s) >>> FRAC_Y);
    tot = r + cur[0] + cur[1] + cur[2];
    pe = rel ? r : sat(tot);
    @(negedge clk);
    vld_in = 1'b0;
    chk("R9 valid", int'(vld_out), 1);
    for (int k = 0; k < DEG; k++) begin
      int e;
      e = rel ? r : sat(tot - cur[k]);
      chk(rel ? "R5 edge" : "R4 edge", int'($signed(vmsg_out[k*MSG_W +: MSG_W])), e);
    end
    chk(rel ? "R2/R6 post" : "R1/R6/R8 post", int'(post_out), pe);
    chk("R7 hard", int'(hard_out), (pe <= 0) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int scl [5];
    int pv;
    scl = '{0, 1, 5, 12, 31};
    cur[0] = 0; cur[1] = 0; cur[2] = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid", int'(vld_out), 0);
    chk("R10 msgs", int'(vmsg_out != '0), 0);
    chk("R10 post", int'(post_out), 0);
    chk("R10 hard", int'(hard_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 after release", int'(vld_out | hard_out), 0);

    // R7 exact zero with empty store
    fire(0, 12, 0, 0);
    // R7 exact zero from cancelling messages: y=4,s=8 -> R=8
    load(-5, -3, 0);
    fire(4, 8, 0, 0);
    // R8 upper and lower clamps
    load(127, 127, 127);
    fire(31, 31, 0, 0);
    load(-128, -128, -128);
    fire(-32, 31, 0, 1);
    // R5 reliable ignores strong opposing messages
    fire(-32, 31, 1, 0);
    fire(31, 31, 1, 1);

    // R3 clear with simultaneous write, then edges equal channel value
    load(90, -70, 40);
    @(negedge clk);
    run_start = 1'b1; cmsg_we = 1'b1; cmsg_in = {3{8'sd100}};
    @(negedge clk);
    run_start = 1'b0; cmsg_we = 1'b0;
    cur[0] = 0; cur[1] = 0; cur[2] = 0;
    fire(9, 7, 0, 0);

    // R9 hold: no request, results unchanged
    pv = int'(post_out);
    load(1, 2, 3);
    @(negedge clk);
    chk("R9 no valid", int'(vld_out), 0);
    chk("R9 post holds", int'(post_out), pv);

    // Sweep: every sample, several scales, reliable and not
    for (int y = -32; y < 32; y++) begin
      for (int si = 0; si < 5; si++) begin
        int m0, m1, m2;
        m0 = ((y + 32) * 37 + si * 53 + 11) % 256 - 128;
        m1 = ((y + 32) * 91 + si * 17 + 5) % 256 - 128;
        m2 = ((y + 32) * 13 + si * 71 + 99) % 256 - 128;
        load(m0, m1, m2);
        fire(y, scl[si], 0, (y & 1) != 0);   // R1 outer bit ignored
        fire(y, scl[si], 1, 1'b0);
        fire(y, scl[si], 1, 1'b1);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule